// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Accumulator

This block keeps a 64-bit accumulator for fixed-point signal processing and runs one command on it each time it is started. Four commands multiply one chosen 16-bit halfword of each 32-bit source as signed numbers. The 32-bit product is sign-extended to 64 bits and shifted left by 16. The multiply commands then load this value into the accumulator, and the multiply-accumulate commands add it to the accumulator.

A round command brings the accumulator back to a signed 16.16 word held in bits 63:32. It first scales the accumulator up by one or two bit positions, then adds half of the low word's weight. The result is clamped to the signed window that this word can hold, and the low word is cleared. Move commands read a 32-bit slice of the accumulator on `result_o`, or load the upper or lower half from `src_a_i`.

A command is taken on a clock edge where `start_i` is high. The next state and any read data appear, together with a one-cycle `done_o` pulse, in the cycle that follows.

Top module: `dsp_acc_unit`

## Requirements
- R1: After reset the accumulator is zero, `result_o` is zero and `done_o` is low.
- R2: For every clock edge that samples `start_i` high, `done_o` is high for exactly the following cycle. Without a start, `done_o` stays low.
- R3: Opcode 0 (multiply upper) loads the accumulator with the signed product of `src_a_i[31:16]` and `src_b_i[31:16]`, sign-extended to 64 bits and shifted left by 16.
- R4: Opcode 1 (multiply lower) does the same as R3 using bits 15:0 of both sources.
- R5: Opcodes 2 (upper halves) and 3 (lower halves) add the shifted product of R3 or R4 to the accumulator, modulo 2^64.
- R6: Opcode 4 (round) shifts the accumulator left by 1 when `round_by2_i` is 0, or by 2 when it is 1. It then adds 0x80000000 and clears bits 31:0.
- R7: In the round command, a signed sum above 0x00007FFF00000000 gives exactly that value. A signed sum below 0xFFFF800000000000 gives exactly that value.
- R8: Opcode 5 returns accumulator bits 63:32, opcode 6 bits 47:16 and opcode 7 bits 31:0 on `result_o` in the `done_o` cycle. The accumulator is unchanged.
- R9: Opcode 8 replaces only bits 63:32 with `src_a_i`, and opcode 9 replaces only bits 31:0 with `src_a_i`.
- R10: Opcodes 10 to 15 leave the accumulator and `result_o` unchanged but still produce the `done_o` pulse.
- R11: `result_o` changes only on the read opcodes 5 to 7. It holds its value across all other commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts the command on `op_i` |
| op_i | input | 4 | Command code |
| src_a_i | input | 32 | First source; data for the move-to commands |
| src_b_i | input | 32 | Second source |
| round_by2_i | input | 1 | Round pre-shift: 0 shifts by 1, 1 shifts by 2 |
| result_o | output | 32 | Read data from the move-from commands |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The multiplies use operand pairs that tell the upper and lower halfword apart: each source carries different values in its two halves, so taking the wrong half gives a different product. The pairs mix positive and negative halves and include the most negative 16-bit value. Accumulate chains alternate signs and check that carries cross the word boundary. Rounding is tried with both shift amounts and with sums that fall inside the window, above it and below it. The read of bits 47:16 uses an accumulator pattern whose three slices all differ, and the unused opcodes are followed by reads that show the state was not touched.

// File: rtl/dsp_acc_pkg.sv
`timescale 1ns/1ps
package dsp_acc_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_MUL_HI = 4'd0,
      OP_MUL_LO = 4'd1,
      OP_MAC_HI = 4'd2,
      OP_MAC_LO = 4'd3,
      OP_ROUND  = 4'd4,
      OP_RD_HI  = 4'd5,
      OP_RD_MID = 4'd6,
      OP_RD_LO  = 4'd7,
      OP_WR_HI  = 4'd8,
      OP_WR_LO  = 4'd9
   } acc_op_e;

   // read window select
   typedef enum logic [1:0] {
      WIN_HI  = 2'd0,
      WIN_MID = 2'd1,
      WIN_LO  = 2'd2,
      WIN_NONE = 2'd3
   } win_sel_e;

endpackage

// File: rtl/dsp_acc_mult.sv
`timescale 1ns/1ps
module dsp_acc_mult #(
   parameter int  DATA_W     = 32,
   parameter int  HALF_W     = 16,
   parameter int  ACC_W      = 64,
   parameter bit  SHARED_MUL = 1'b1
) (
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic              hi_sel,
   output logic [ACC_W-1:0]  prod_sh
);
   localparam int PROD_W = 2 * HALF_W;
   localparam int EXT_W  = ACC_W - PROD_W;

   if (DATA_W != 2 * HALF_W) begin : g_chk_half
      $error("dsp_acc_mult: DATA_W must be twice HALF_W");
   end
   if (ACC_W < PROD_W + HALF_W) begin : g_chk_acc
      $error("dsp_acc_mult: ACC_W too narrow for shifted product");
   end

   logic [PROD_W-1:0] prod;

   function automatic logic [PROD_W-1:0] smul(input logic [HALF_W-1:0] x,
                                              input logic [HALF_W-1:0] y);
      logic [PROD_W-1:0] xe, ye;
      xe = {{HALF_W{x[HALF_W-1]}}, x};
      ye = {{HALF_W{y[HALF_W-1]}}, y};
      return xe * ye;
   endfunction

   if (SHARED_MUL) begin : g_shared
      logic [HALF_W-1:0] ha, hb;
      always_comb begin
         ha = hi_sel ? src_a[DATA_W-1:HALF_W] : src_a[HALF_W-1:0];
         hb = hi_sel ? src_b[DATA_W-1:HALF_W] : src_b[HALF_W-1:0];
      end
      assign prod = smul(ha, hb);
   end else begin : g_dual
      logic [PROD_W-1:0] p_hi, p_lo;
      assign p_hi = smul(src_a[DATA_W-1:HALF_W], src_b[DATA_W-1:HALF_W]);
      assign p_lo = smul(src_a[HALF_W-1:0], src_b[HALF_W-1:0]);
      assign prod = hi_sel ? p_hi : p_lo;
   end

   assign prod_sh = {{EXT_W{prod[PROD_W-1]}}, prod} << HALF_W;

endmodule

// File: rtl/dsp_acc_round.sv
`timescale 1ns/1ps
module dsp_acc_round #(
   parameter int DATA_W = 32,
   parameter int HALF_W = 16,
   parameter int ACC_W  = 64
) (
   input  logic [ACC_W-1:0] acc,
   input  logic             by2,
   output logic [ACC_W-1:0] rounded
);
   localparam logic [ACC_W-1:0] ONE     = ACC_W'(1);
   localparam logic [ACC_W-1:0] HALF    = ONE << (DATA_W - 1);
   localparam logic [ACC_W-1:0] TOP_BIT = ONE << (DATA_W + HALF_W - 1);
   localparam logic [ACC_W-1:0] SAT_HI  = TOP_BIT - (ONE << DATA_W);
   localparam logic [ACC_W-1:0] SAT_LO  = ~TOP_BIT + ONE;

   if (ACC_W != 2 * DATA_W) begin : g_chk_w
      $error("dsp_acc_round: ACC_W must be twice DATA_W");
   end

   logic [ACC_W-1:0] scaled, sum;

   always_comb begin
      scaled = by2 ? (acc << 2) : (acc << 1);
      sum    = scaled + HALF;
      if ($signed(sum) > $signed(SAT_HI))
         rounded = SAT_HI;
      else if ($signed(sum) < $signed(SAT_LO))
         rounded = SAT_LO;
      else
         rounded = {sum[ACC_W-1:DATA_W], {DATA_W{1'b0}}};
   end

endmodule

// File: rtl/dsp_acc_slice.sv
`timescale 1ns/1ps
module dsp_acc_slice
   import dsp_acc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int HALF_W = 16,
   parameter int ACC_W  = 64
) (
   input  logic [ACC_W-1:0]  acc,
   input  win_sel_e          sel,
   output logic [DATA_W-1:0] word
);
   localparam int N_WIN = 4;

   if (ACC_W < DATA_W + HALF_W + HALF_W) begin : g_chk_w
      $error("dsp_acc_slice: ACC_W too narrow for the three windows");
   end

   logic [DATA_W-1:0] win [N_WIN];

   for (genvar w = 0; w < N_WIN; w++) begin : g_win
      if (w == int'(WIN_HI)) begin : g_hi
         assign win[w] = acc[ACC_W-1 -: DATA_W];
      end else if (w == int'(WIN_MID)) begin : g_mid
         assign win[w] = acc[HALF_W +: DATA_W];
      end else if (w == int'(WIN_LO)) begin : g_lo
         assign win[w] = acc[DATA_W-1:0];
      end else begin : g_none
         assign win[w] = '0;
      end
   end

   assign word = win[sel];

endmodule

// File: rtl/dsp_acc_unit.sv
`timescale 1ns/1ps
module dsp_acc_unit
   import dsp_acc_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int HALF_W     = 16,
   parameter int ACC_W      = 64,
   parameter bit SHARED_MUL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] src_a_i,
   input  logic [DATA_W-1:0] src_b_i,
   input  logic              round_by2_i,
   output logic [DATA_W-1:0] result_o,
   output logic              done_o
);
   localparam logic [ACC_W-1:0] WIN_TOP = ACC_W'(1) << (DATA_W + HALF_W - 1);
   localparam logic [ACC_W-1:0] WIN_MAX = WIN_TOP - (ACC_W'(1) << DATA_W);
   localparam logic [ACC_W-1:0] WIN_MIN = ~WIN_TOP + ACC_W'(1);

   if (ACC_W != 2 * DATA_W) begin : g_chk_acc
      $error("dsp_acc_unit: ACC_W must be twice DATA_W");
   end
   if (DATA_W != 2 * HALF_W) begin : g_chk_half
      $error("dsp_acc_unit: DATA_W must be twice HALF_W");
   end

   acc_op_e           op;
   logic [ACC_W-1:0]  acc_q, acc_nxt;
   logic [ACC_W-1:0]  prod_sh, rnd_val;
   logic [DATA_W-1:0] rd_word;
   logic              hi_sel, is_read;
   win_sel_e          win;

   assign op = acc_op_e'(op_i);

   always_comb begin
      hi_sel  = (op == OP_MUL_HI) || (op == OP_MAC_HI);
      is_read = 1'b1;
      case (op)
         OP_RD_HI:  win = WIN_HI;
         OP_RD_MID: win = WIN_MID;
         OP_RD_LO:  win = WIN_LO;
         default: begin
            win     = WIN_NONE;
            is_read = 1'b0;
         end
      endcase
   end

   dsp_acc_mult #(
      .DATA_W(DATA_W), .HALF_W(HALF_W), .ACC_W(ACC_W), .SHARED_MUL(SHARED_MUL)
   ) u_mult (
      .src_a(src_a_i), .src_b(src_b_i), .hi_sel(hi_sel), .prod_sh(prod_sh)
   );

   dsp_acc_round #(
      .DATA_W(DATA_W), .HALF_W(HALF_W), .ACC_W(ACC_W)
   ) u_round (
      .acc(acc_q), .by2(round_by2_i), .rounded(rnd_val)
   );

   dsp_acc_slice #(
      .DATA_W(DATA_W), .HALF_W(HALF_W), .ACC_W(ACC_W)
   ) u_slice (
      .acc(acc_q), .sel(win), .word(rd_word)
   );

   always_comb begin
      acc_nxt = acc_q;
      case (op)
         OP_MUL_HI, OP_MUL_LO: acc_nxt = prod_sh;
         OP_MAC_HI, OP_MAC_LO: acc_nxt = acc_q + prod_sh;
         OP_ROUND:             acc_nxt = rnd_val;
         OP_WR_HI:             acc_nxt = {src_a_i, acc_q[DATA_W-1:0]};
         OP_WR_LO:             acc_nxt = {acc_q[ACC_W-1:DATA_W], src_a_i};
         default:              acc_nxt = acc_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         result_o <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= start_i;
         if (start_i) begin
            acc_q <= acc_nxt;
            if (is_read)
               result_o <= rd_word;
         end
      end
   end

   AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o); // R2
   AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(start_i)); // R2
   AST_IDLE_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(acc_q) && $stable(result_o)); // R10
   AST_READ_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && is_read) |=> $stable(acc_q)); // R8
   AST_WR_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op == OP_WR_HI) |=> acc_q[DATA_W-1:0] == $past(acc_q[DATA_W-1:0])); // R9
   AST_WR_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op == OP_WR_LO) |=> acc_q[ACC_W-1:DATA_W] == $past(acc_q[ACC_W-1:DATA_W])); // R9
   AST_ROUND_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op == OP_ROUND) |=> (acc_q[DATA_W-1:0] == '0)
         && ($signed(acc_q) <= $signed(WIN_MAX)) && ($signed(acc_q) >= $signed(WIN_MIN))); // R7
   AST_RESULT_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !is_read) |=> $stable(result_o)); // R11

endmodule

// File: tb/dsp_acc_unit_test.sv
`timescale 1ns/1ps
module dsp_acc_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [3:0]  op_i = '0;
   logic [31:0] src_a_i = '0;
   logic [31:0] src_b_i = '0;
   logic        round_by2_i = 1'b0;
   logic [31:0] result_o;
   logic        done_o;

   int checks = 0;
   int fails  = 0;
   logic [63:0] acc_m = '0;

   always #10 clk = ~clk;

   dsp_acc_unit uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .src_a_i(src_a_i), .src_b_i(src_b_i), .round_by2_i(round_by2_i),
      .result_o(result_o), .done_o(done_o)
   );

   typedef struct packed {
      logic [3:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic        r;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{4'd0, 32'h0003_1111, 32'hFFFE_2222, 1'b0},
      '{4'd2, 32'h7FFF_0001, 32'h7FFF_0002, 1'b0},
      '{4'd1, 32'h1234_8000, 32'h5678_8000, 1'b0},
      '{4'd3, 32'h0000_FFFF, 32'h0000_0001, 1'b0},
      '{4'd3, 32'hAAAA_8000, 32'hBBBB_7FFF, 1'b0},
      '{4'd2, 32'hFFFF_0000, 32'h8000_0000, 1'b0},
      '{4'd8, 32'h0000_0001, 32'h0000_0000, 1'b0},
      '{4'd9, 32'h8000_0000, 32'h0000_0000, 1'b0},
      '{4'd4, 32'h0000_0000, 32'h0000_0000, 1'b1},
      '{4'd0, 32'h8000_0000, 32'h8000_0000, 1'b0},
      '{4'd4, 32'h0000_0000, 32'h0000_0000, 1'b0},
      '{4'd0, 32'h8000_0000, 32'h7FFF_0000, 1'b0},
      '{4'd4, 32'h0000_0000, 32'h0000_0000, 1'b1},
      '{4'd1, 32'h0000_7FFF, 32'h0000_8000, 1'b0}
   };

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd0: return "R3";
         4'd1: return "R4";
         4'd2, 4'd3: return "R5";
         4'd4: return "R6";
         4'd8, 4'd9: return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic logic [63:0] model(input logic [63:0] acc, input logic [3:0] op,
                                         input logic [31:0] a, input logic [31:0] b,
                                         input logic r);
      logic signed [31:0] p;
      logic signed [63:0] s, t;
      case (op)
         4'd0, 4'd2: p = $signed(a[31:16]) * $signed(b[31:16]);
         default:    p = $signed(a[15:0]) * $signed(b[15:0]);
      endcase
      s = p;
      s = s <<< 16;
      case (op)
         4'd0, 4'd1: return s;
         4'd2, 4'd3: return acc + s;
         4'd4: begin
            t = $signed(acc << (r ? 2 : 1)) + 64'sh0000_0000_8000_0000;
            if (t > 64'sh0000_7FFF_0000_0000) return 64'h0000_7FFF_0000_0000;
            if (t < $signed(64'hFFFF_8000_0000_0000)) return 64'hFFFF_8000_0000_0000;
            return {t[63:32], 32'h0};
         end
         4'd8: return {a, acc[31:0]};
         4'd9: return {acc[63:32], a};
         default: return acc;
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // issue one command; res is result_o sampled in the done cycle
   task automatic do_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic r, output logic [31:0] res);
      @(negedge clk);
      op_i = op; src_a_i = a; src_b_i = b; round_by2_i = r; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R2", "done pulse", 64'(done_o), 64'd1);
      res = result_o;
      acc_m = model(acc_m, op, a, b, r);
      @(negedge clk);
      chk("R2", "done width", 64'(done_o), 64'd0);
   endtask

   task automatic read_acc(input string req);
      logic [31:0] hi, lo;
      do_op(4'd5, 32'h0, 32'h0, 1'b0, hi);
      chk(req, "acc high word", 64'(hi), 64'(acc_m[63:32]));
      do_op(4'd7, 32'h0, 32'h0, 1'b0, lo);
      chk(req, "acc low word", 64'(lo), 64'(acc_m[31:0]));
   endtask

   task automatic load_acc(input logic [63:0] v);
      logic [31:0] dummy;
      do_op(4'd8, v[63:32], 32'h0, 1'b0, dummy);
      do_op(4'd9, v[31:0], 32'h0, 1'b0, dummy);
   endtask

   task automatic round_expect(input string req, input logic [63:0] start_v, input logic r,
                               input logic [31:0] exp_hi);
      logic [31:0] hi, lo;
      load_acc(start_v);
      do_op(4'd4, 32'h0, 32'h0, r, hi);
      do_op(4'd5, 32'h0, 32'h0, 1'b0, hi);
      chk(req, "rounded high word", 64'(hi), 64'(exp_hi));
      do_op(4'd7, 32'h0, 32'h0, 1'b0, lo);
      chk(req, "rounded low word", 64'(lo), 64'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] res, keep;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "result after reset", 64'(result_o), 64'd0);
      chk("R1", "done after reset", 64'(done_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2", "done idle", 64'(done_o), 64'd0);
      read_acc("R1");

      for (int i = 0; i < NV; i++) begin
         do_op(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].r, res);
         read_acc(tag_of(VECS[i].op));
      end

      // R8: middle window
      load_acc(64'h1234_5678_9ABC_DEF0);
      do_op(4'd6, 32'h0, 32'h0, 1'b0, res);
      chk("R8", "middle slice", 64'(res), 64'h5678_9ABC);
      do_op(4'd5, 32'h0, 32'h0, 1'b0, res);
      chk("R8", "high slice", 64'(res), 64'h1234_5678);
      do_op(4'd7, 32'h0, 32'h0, 1'b0, res);
      chk("R8", "low slice", 64'(res), 64'h9ABC_DEF0);

      // R10: reserved opcodes touch nothing
      keep = result_o;
      for (int op = 10; op < 16; op++) begin
         do_op(4'(op), 32'hFFFF_FFFF, 32'h1234_5678, 1'b1, res);
         chk("R10", "result after reserved op", 64'(res), 64'(keep));
      end
      read_acc("R10");

      // R11: result holds across non-read commands
      keep = result_o;
      do_op(4'd0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 1'b0, res);
      chk("R11", "result after multiply", 64'(res), 64'(keep));
      do_op(4'd8, 32'hCAFE_0000, 32'h0, 1'b0, res);
      chk("R11", "result after write", 64'(res), 64'(keep));
      do_op(4'd4, 32'h0, 32'h0, 1'b0, res);
      chk("R11", "result after round", 64'(res), 64'(keep));

      // R6 / R7: directed rounding points
      round_expect("R6", 64'h0000_0001_8000_0000, 1'b1, 32'h0000_0006);
      round_expect("R6", 64'h0000_0001_8000_0000, 1'b0, 32'h0000_0003);
      round_expect("R6", 64'h0000_0000_C000_0000, 1'b0, 32'h0000_0002);
      round_expect("R7", 64'h0000_FFFF_0000_0000, 1'b0, 32'h0000_7FFF);
      round_expect("R7", 64'hFFFF_0000_0000_0000, 1'b0, 32'hFFFF_8000);
      round_expect("R7", 64'h0000_3FFF_4000_0000, 1'b0, 32'h0000_7FFF);

      // R2: back-to-back starts give one pulse per start
      @(negedge clk);
      op_i = 4'd7; start_i = 1'b1;
      @(negedge clk);
      chk("R2", "first of two", 64'(done_o), 64'd1);
      @(negedge clk);
      start_i = 1'b0;
      chk("R2", "second of two", 64'(done_o), 64'd1);
      @(negedge clk);
      chk("R2", "after pair", 64'(done_o), 64'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule